// File: doc/BRIEF.md
# Branch Resolution and Program Counter Unit

This block owns the program counter of a small 64-bit teaching core and settles, every cycle, where the next instruction comes from. It looks at the 32-bit instruction just fetched and recognises three branch families. The first is the unconditional jump. The second is the test of a register against zero, in either sense. The third is the branch on the stored N, Z, C and V condition flags. For each family it pulls out the word offset, sign-extends it and scales it to bytes, adds it to the current PC, and decides whether the branch is taken.

Two results are combinational: the taken decision and the computed target. A pipeline can use them right away to flush younger stages. The chosen next PC is either the target or the sequential address four bytes on. It is loaded into the PC register on a rising clock edge while the enable input is high. The register-test family reads the low five instruction bits as the register whose value arrives on `rt_val`. The flag family reads the same five bits as a condition selector.

Top module: `brpc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is zero.
- R2: On a rising edge with `pc_en` low, `pc_q` keeps its value, whatever instruction is presented.
- R3: An instruction outside the three branch encodings gives `br_taken` = 0, `br_target` = `pc_q`+4 and `pc_next` = `pc_q`+4.
- R4: An instruction with bits [31:26] = 000101 is always taken. Its target is `pc_q` + 4 × (bits [25:0] read as a signed number).
- R5: An instruction with bits [31:24] = 10110100 has the target `pc_q` + 4 × (bits [23:5] read as signed). It is taken exactly when `rt_val` is zero.
- R6: An instruction with bits [31:24] = 10110101 has the same target rule as R5. It is taken exactly when `rt_val` is non-zero.
- R7: An instruction with bits [31:24] = 01010100 has the same target rule as R5. It is taken when the condition coded in bits [4:0] holds on `flags_nzcv` (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V). The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
- R8: A flag-conditional branch with condition code 01110 or any higher value is not taken.
- R9: Offsets with their top bit set move the target backwards, across the full range of both offset widths.
- R10: On a rising edge with `pc_en` high, `pc_q` takes the value `pc_next` had before the edge. `pc_next` is `br_target` when `br_taken` is 1 and `pc_q`+4 otherwise.
- R11: The flag-conditional decision does not depend on `rt_val`. The register-test decisions do not depend on `flags_nzcv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| pc_en | input | 1 | Allows the PC to advance on this edge |
| instr | input | 32 | Instruction fetched at `pc_q` |
| rt_val | input | 64 | Value of the register named in instruction bits [4:0] |
| flags_nzcv | input | 4 | Condition flags N, Z, C, V in bits 3 down to 0 |
| pc_q | output | 64 | Current program counter |
| br_taken | output | 1 | Branch taken, combinational |
| br_target | output | 64 | Branch target, or PC+4 for a non-branch, combinational |
| pc_next | output | 64 | Value the PC loads at the next enabled edge |

## Verification
The assertions assume that `instr`, `rt_val` and `flags_nzcv` are settled and free of X at every rising edge once reset is released. They also assume that `rst_n` is only released between edges. The bench drives every input on the falling edge and releases reset there, so each edge sees stable, known values. Every input is also given a value at time zero. This keeps the combinational decision checks meaningful from the first sampled edge.

// File: rtl/brpc_pkg.sv
package brpc_pkg;

  typedef enum logic [1:0] {
    BK_NONE   = 2'd0,
    BK_UNCOND = 2'd1,
    BK_REGTST = 2'd2,
    BK_FLAG   = 2'd3
  } br_kind_e;

  localparam logic [5:0] OPC_JUMP   = 6'b000101;
  localparam logic [7:0] OPC_ZTEST  = 8'b10110100;
  localparam logic [7:0] OPC_NZTEST = 8'b10110101;
  localparam logic [7:0] OPC_FLAGBR = 8'b01010100;

  localparam int JUMP_IMM_W = 26;
  localparam int TEST_IMM_W = 19;
  localparam int SEL_W      = 5;

  typedef enum logic [SEL_W-1:0] {
    CS_ZSET  = 5'd0,
    CS_ZCLR  = 5'd1,
    CS_CSET  = 5'd2,
    CS_CCLR  = 5'd3,
    CS_NSET  = 5'd4,
    CS_NCLR  = 5'd5,
    CS_VSET  = 5'd6,
    CS_VCLR  = 5'd7,
    CS_UHI   = 5'd8,
    CS_ULE   = 5'd9,
    CS_SGE   = 5'd10,
    CS_SLT   = 5'd11,
    CS_SGT   = 5'd12,
    CS_SLE   = 5'd13
  } cond_sel_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

endpackage

// File: rtl/brpc_decode.sv
module brpc_decode
  import brpc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0]  instr,
  output br_kind_e         kind,
  output logic             test_nonzero,
  output logic [SEL_W-1:0] sel,
  output logic [XLEN-1:0]  offset_bytes
);

  localparam int JUMP_EXT = XLEN - JUMP_IMM_W - 2;
  localparam int TEST_EXT = XLEN - TEST_IMM_W - 2;

  logic [JUMP_IMM_W-1:0] jump_imm;
  logic [TEST_IMM_W-1:0] test_imm;
  logic [XLEN-1:0]       jump_off;
  logic [XLEN-1:0]       test_off;

  generate
    if (XLEN < JUMP_IMM_W + 2 || ILEN != 32) begin : g_bad_cfg
      initial $error("brpc_decode: unsupported width configuration");
    end
  endgenerate

  assign jump_imm = instr[JUMP_IMM_W-1:0];
  assign test_imm = instr[TEST_IMM_W+SEL_W-1:SEL_W];
  assign sel      = instr[SEL_W-1:0];

  // sign-extend word counts, then scale to bytes
  assign jump_off = {{JUMP_EXT{jump_imm[JUMP_IMM_W-1]}}, jump_imm, 2'b00};
  assign test_off = {{TEST_EXT{test_imm[TEST_IMM_W-1]}}, test_imm, 2'b00};

  always_comb begin
    kind         = BK_NONE;
    test_nonzero = 1'b0;
    if (instr[31:26] == OPC_JUMP) begin
      kind = BK_UNCOND;
    end else if (instr[31:24] == OPC_ZTEST) begin
      kind = BK_REGTST;
    end else if (instr[31:24] == OPC_NZTEST) begin
      kind         = BK_REGTST;
      test_nonzero = 1'b1;
    end else if (instr[31:24] == OPC_FLAGBR) begin
      kind = BK_FLAG;
    end
  end

  always_comb begin
    unique case (kind)
      BK_UNCOND: offset_bytes = jump_off;
      BK_REGTST,
      BK_FLAG:   offset_bytes = test_off;
      default:   offset_bytes = '0;
    endcase
  end

endmodule

// File: rtl/brpc_cond.sv
module brpc_cond
  import brpc_pkg::*;
(
  input  logic [3:0]       flags_nzcv,
  input  logic [SEL_W-1:0] sel,
  output logic             pass
);

  logic fn, fz, fc, fv, sge;

  assign fn  = flags_nzcv[FLG_N];
  assign fz  = flags_nzcv[FLG_Z];
  assign fc  = flags_nzcv[FLG_C];
  assign fv  = flags_nzcv[FLG_V];
  assign sge = (fn == fv);

  always_comb begin
    case (sel)
      CS_ZSET: pass = fz;
      CS_ZCLR: pass = !fz;
      CS_CSET: pass = fc;
      CS_CCLR: pass = !fc;
      CS_NSET: pass = fn;
      CS_NCLR: pass = !fn;
      CS_VSET: pass = fv;
      CS_VCLR: pass = !fv;
      CS_UHI:  pass = fc && !fz;
      CS_ULE:  pass = !fc || fz;
      CS_SGE:  pass = sge;
      CS_SLT:  pass = !sge;
      CS_SGT:  pass = !fz && sge;
      CS_SLE:  pass = fz || !sge;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/brpc_pc_reg.sv
module brpc_pc_reg #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);

  logic [XLEN-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_PC;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/brpc_unit.sv
module brpc_unit
  import brpc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_en,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] rt_val,
  input  logic [3:0]      flags_nzcv,
  output logic [XLEN-1:0] pc_q,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic [XLEN-1:0] pc_next
);

  localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(ILEN / 8);

  br_kind_e         kind;
  logic             test_nonzero;
  logic [SEL_W-1:0] sel;
  logic [XLEN-1:0]  offset_bytes;
  logic             cond_pass;
  logic             rt_is_zero;
  logic [XLEN-1:0]  pc_seq;

  brpc_decode #(.XLEN(XLEN), .ILEN(ILEN)) dec_i (
    .instr        (instr),
    .kind         (kind),
    .test_nonzero (test_nonzero),
    .sel          (sel),
    .offset_bytes (offset_bytes)
  );

  brpc_cond cond_i (
    .flags_nzcv (flags_nzcv),
    .sel        (sel),
    .pass       (cond_pass)
  );

  assign rt_is_zero = (rt_val == '0);
  assign pc_seq     = pc_q + STEP_BYTES;

  always_comb begin
    unique case (kind)
      BK_UNCOND: br_taken = 1'b1;
      BK_REGTST: br_taken = test_nonzero ? !rt_is_zero : rt_is_zero;
      BK_FLAG:   br_taken = cond_pass;
      default:   br_taken = 1'b0;
    endcase
  end

  assign br_target = (kind == BK_NONE) ? pc_seq : (pc_q + offset_bytes);
  assign pc_next   = br_taken ? br_target : pc_seq;

  brpc_pc_reg #(.XLEN(XLEN)) pc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (pc_en),
    .d     (pc_next),
    .q     (pc_q)
  );

endmodule

// File: rtl/brpc_unit_chk.sv
module brpc_unit_chk #(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pc_en,
  input logic [ILEN-1:0] instr,
  input logic [XLEN-1:0] rt_val,
  input logic [3:0]      flags_nzcv,
  input logic [XLEN-1:0] pc_q,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target,
  input logic [XLEN-1:0] pc_next
);

  logic is_jump, is_zt, is_nzt, is_fb, any_br;

  assign is_jump = (instr[31:26] == 6'b000101);
  assign is_zt   = (instr[31:24] == 8'hB4);
  assign is_nzt  = (instr[31:24] == 8'hB5);
  assign is_fb   = (instr[31:24] == 8'h54);
  assign any_br  = is_jump || is_zt || is_nzt || is_fb;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> pc_q == '0);

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |=> $stable(pc_q));

  // R10
  load_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en |=> pc_q == $past(pc_next));

  // R3
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_br |-> (!br_taken && pc_next == pc_q + XLEN'(4) && br_target == pc_next));

  // R4
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |-> (br_taken && pc_next == br_target));

  // R5
  zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_zt |-> (br_taken == (rt_val == '0)));

  // R6
  nonzero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nzt |-> (br_taken == (rt_val != '0)));

  // R8
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fb && instr[4:0] >= 5'd14) |-> !br_taken);

  // R10
  next_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |-> pc_next == pc_q + XLEN'(4));

endmodule

bind brpc_unit brpc_unit_chk #(.XLEN(XLEN), .ILEN(ILEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_en      (pc_en),
  .instr      (instr),
  .rt_val     (rt_val),
  .flags_nzcv (flags_nzcv),
  .pc_q       (pc_q),
  .br_taken   (br_taken),
  .br_target  (br_target),
  .pc_next    (pc_next)
);

// File: tb/brpc_unit_tb_top.sv
module brpc_unit_tb_top;

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] rt;
    logic [3:0]  nzcv;
    logic        tk;
    logic [63:0] off;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;

  // off: expected br_target minus pc_q; req: requirement number of the row
  localparam vec_t VECS [NV] = '{
    '{32'h8B150289, 64'd0,     4'h0, 1'b0, 64'd4,                 4'd3},  // R3 non-branch
    '{32'hB6000000, 64'd0,     4'h0, 1'b0, 64'd4,                 4'd3},  // R3 near opcode
    '{32'h55000000, 64'd0,     4'hF, 1'b0, 64'd4,                 4'd3},  // R3 near opcode
    '{32'h14000003, 64'd0,     4'h0, 1'b1, 64'd12,                4'd4},  // R4
    '{32'h17FFFFFF, 64'd0,     4'h0, 1'b1, 64'hFFFFFFFFFFFFFFFC,  4'd9},  // R9 jump -1 word
    '{32'h16000000, 64'd0,     4'h0, 1'b1, 64'hFFFFFFFFF8000000,  4'd9},  // R9 jump minimum
    '{32'hB4000043, 64'd0,     4'hF, 1'b1, 64'd8,                 4'd5},  // R5 zero
    '{32'hB4000043, 64'd5,     4'h4, 1'b0, 64'd8,                 4'd5},  // R5 non-zero
    '{32'hB5000043, 64'd5,     4'h0, 1'b1, 64'd8,                 4'd6},  // R6 non-zero
    '{32'hB5000043, 64'd0,     4'hF, 1'b0, 64'd8,                 4'd6},  // R6 zero
    '{32'hB4FFFFE0, 64'd0,     4'h0, 1'b1, 64'hFFFFFFFFFFFFFFFC,  4'd9},  // R9 test -1 word
    '{32'hB4800000, 64'd0,     4'h0, 1'b1, 64'hFFFFFFFFFFF00000,  4'd9},  // R9 test minimum
    '{32'h54000080, 64'd0,     4'h4, 1'b1, 64'd16,                4'd7},  // R7 code 0
    '{32'h54000080, 64'd0,     4'h0, 1'b0, 64'd16,                4'd7},
    '{32'h54000081, 64'd0,     4'h0, 1'b1, 64'd16,                4'd7},  // R7 code 1
    '{32'h54000081, 64'd0,     4'h4, 1'b0, 64'd16,                4'd7},
    '{32'h54000082, 64'd0,     4'h2, 1'b1, 64'd16,                4'd7},  // R7 code 2
    '{32'h54000083, 64'd0,     4'h2, 1'b0, 64'd16,                4'd7},  // R7 code 3
    '{32'h54000083, 64'd0,     4'h0, 1'b1, 64'd16,                4'd7},
    '{32'h54000084, 64'd0,     4'h8, 1'b1, 64'd16,                4'd7},  // R7 code 4
    '{32'h54000085, 64'd0,     4'h8, 1'b0, 64'd16,                4'd7},  // R7 code 5
    '{32'h54000086, 64'd0,     4'h1, 1'b1, 64'd16,                4'd7},  // R7 code 6
    '{32'h54000087, 64'd0,     4'h0, 1'b1, 64'd16,                4'd7},  // R7 code 7
    '{32'h54000087, 64'd0,     4'h1, 1'b0, 64'd16,                4'd7},
    '{32'h54000088, 64'd0,     4'h2, 1'b1, 64'd16,                4'd7},  // R7 code 8
    '{32'h54000088, 64'd0,     4'h6, 1'b0, 64'd16,                4'd7},
    '{32'h54000089, 64'd0,     4'h6, 1'b1, 64'd16,                4'd7},  // R7 code 9
    '{32'h54000089, 64'd0,     4'h2, 1'b0, 64'd16,                4'd7},
    '{32'h5400008A, 64'd0,     4'h9, 1'b1, 64'd16,                4'd7},  // R7 code 10
    '{32'h5400008A, 64'd0,     4'h8, 1'b0, 64'd16,                4'd7},
    '{32'h5400008B, 64'd0,     4'h8, 1'b1, 64'd16,                4'd7},  // R7 code 11
    '{32'h5400008B, 64'd0,     4'h9, 1'b0, 64'd16,                4'd7},
    '{32'h5400008C, 64'd0,     4'h9, 1'b1, 64'd16,                4'd7},  // R7 code 12
    '{32'h5400008C, 64'd0,     4'hD, 1'b0, 64'd16,                4'd7},
    '{32'h5400008D, 64'd0,     4'h4, 1'b1, 64'd16,                4'd7},  // R7 code 13
    '{32'h5400008D, 64'd0,     4'h9, 1'b0, 64'd16,                4'd7},
    '{32'h5400008E, 64'd0,     4'h0, 1'b0, 64'd16,                4'd8},  // R8 code 14
    '{32'h5400008F, 64'd0,     4'hF, 1'b0, 64'd16,                4'd8},  // R8 code 15
    '{32'h5400009F, 64'd0,     4'h0, 1'b0, 64'd16,                4'd8},  // R8 code 31
    '{32'h54000080, 64'h1234,  4'h4, 1'b1, 64'd16,                4'd11}, // R11 rt ignored
    '{32'hB4000043, 64'd0,     4'h0, 1'b1, 64'd8,                 4'd11}, // R11 flags ignored
    '{32'h5400008B, 64'd0,     4'h1, 1'b1, 64'd16,                4'd7}   // R7 code 11, V only
  };

  logic        clk;
  logic        rst_n;
  logic        pc_en;
  logic [31:0] instr;
  logic [63:0] rt_val;
  logic [3:0]  flags_nzcv;
  logic [63:0] pc_q;
  logic        br_taken;
  logic [63:0] br_target;
  logic [63:0] pc_next;

  int n_chk;
  int n_fail;

  brpc_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_en      (pc_en),
    .instr      (instr),
    .rt_val     (rt_val),
    .flags_nzcv (flags_nzcv),
    .pc_q       (pc_q),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .pc_next    (pc_next)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [31:0] ins,
                       input logic [63:0] rt, input logic [3:0] f);
    pc_en      = en;
    instr      = ins;
    rt_val     = rt;
    flags_nzcv = f;
  endtask

  // from a falling edge, pass one rising edge and return at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pc0;
    logic [63:0] exp_tgt;
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    drive(1'b1, 32'h8B150289, 64'd0, 4'h0);

    // R1: reset state
    @(negedge clk);
    step();
    check("R1", "pc_q in reset", pc_q, 64'd0);
    rst_n = 1'b1;

    // R10/R4: jump forward 0x40 words from zero
    drive(1'b1, 32'h14000040, 64'd0, 4'h0);
    #2;
    check("R4", "pc_next before load", pc_next, 64'h100);
    @(negedge clk);
    check("R10", "pc_q after load", pc_q, 64'h100);

    // table walk with PC frozen
    pc_en = 1'b0;
    pc0   = pc_q;
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, VECS[i].ins, VECS[i].rt, VECS[i].nzcv);
      #2;
      exp_tgt = pc0 + VECS[i].off;
      check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d taken", i),
            {63'd0, br_taken}, {63'd0, VECS[i].tk});
      check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d target", i),
            br_target, exp_tgt);
      check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d next", i),
            pc_next, VECS[i].tk ? exp_tgt : pc0 + 64'd4);
      @(negedge clk);
    end

    // R2: a taken jump presented with the enable low leaves the PC alone
    drive(1'b0, 32'h14000003, 64'd0, 4'h0);
    step();
    step();
    check("R2", "pc_q held", pc_q, 64'h100);

    // R10/R3: sequential advance
    drive(1'b1, 32'h8B150289, 64'd0, 4'h0);
    step();
    step();
    step();
    check("R3", "pc_q after three steps", pc_q, 64'h10C);

    // R9/R10: backward jump by one word
    drive(1'b1, 32'h17FFFFFF, 64'd0, 4'h0);
    step();
    check("R9", "pc_q after backward jump", pc_q, 64'h108);

    // R5/R10: taken zero test backwards to below zero (wraps)
    drive(1'b1, 32'hB4800000, 64'd0, 4'h0);
    step();
    check("R5", "pc_q after zero test", pc_q, 64'h108 + 64'hFFFFFFFFFFF00000);

    // R6/R10: non-zero test not taken advances by four
    pc0 = pc_q;
    drive(1'b1, 32'hB5000043, 64'd0, 4'hF);
    step();
    check("R6", "pc_q after untaken test", pc_q, pc0 + 64'd4);

    // R1: reset mid-run
    drive(1'b0, 32'h8B150289, 64'd0, 4'h0);
    rst_n = 1'b0;
    #2;
    check("R1", "pc_q on async reset", pc_q, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 32'h8B150289, 64'd0, 4'h0);
    step();
    check("R1", "pc_q first step after reset", pc_q, 64'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule